// File: doc/BRIEF.md
# Instruction Prefix Classifier Stage

This stage sits at the head of instruction decode. Each accepted beat carries up to two instruction byte windows, one per slot. For every slot it walks the bytes from the first one and recognises prefix bytes, stopping at the first byte that is not a prefix. It reports one flag per prefix kind, the fields carried by the last REX, segment and repeat prefix seen, and the index of the opcode byte.

Prefixes fall into two timing classes. The cheap class is the vector prefix, the two mask-instruction prefixes, REX and the two-byte escape. A beat that holds only these produces its result one cycle after it is accepted, so a new beat can be accepted on every cycle. The expensive class is the legacy group: operand size, address size, lock, segment override and repeat. If any of these is present in any valid slot, the stage drops its ready signal and keeps its output valid low for two extra cycles. It then presents the result. The flags are latched when the beat is accepted.

Top module: `pfx_decode_stage`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_slot_vld` is 0.
- R2: A beat with no expensive prefix in its valid slots is reported one cycle after it is accepted. `in_ready` stays 1, so beats can be accepted on back-to-back cycles.
- R3: A beat with an expensive prefix (0x66, 0x67, 0xF0, 0xF2, 0xF3, 0x26, 0x2E, 0x36, 0x3E, 0x64, 0x65) is reported three cycles after it is accepted. `in_ready` is 0 for exactly the two cycles in between, and `out_slot_vld` is 0 while `in_ready` is 0.
- R4: The two-cycle penalty is charged once per beat, however many expensive prefixes it holds and in however many slots.
- R5: The scan stops at the first non-prefix byte, whose index becomes `out_opc_ptr`. The bytes 0x0F, 0x62, 0xC4 and 0xC5 end the scan as prefixes, and the opcode index is then the byte after them. A window made only of prefixes gives index WIN. In every slot window, byte k sits at bits [8k+7:8k].
- R6: Segment overrides set `out_seg_vld` and a 3-bit code: 0x26→0, 0x2E→1, 0x36→2, 0x3E→3, 0x64→4, 0x65→5. The last override in the window wins.
- R7: Bytes 0x40–0x4F set `out_rex_vld`, and their low nibble appears on `out_rex_bits`. The last REX byte wins.
- R8: 0xF2 gives `out_rep`=01 and 0xF3 gives `out_rep`=10, with the last one winning. 0x66, 0x67, 0xF0, 0x0F, 0x62 and 0xC4/0xC5 set `out_opsz`, `out_adsz`, `out_lock`, `out_esc`, `out_vec` and `out_mask` respectively.
- R9: Both slots are decoded independently in the same beat. `out_slot_vld` repeats the slot mask that was accepted, and each slot's fields sit in its own lane of the output buses (slot s of `out_rex_bits` at [4s+3:4s]).
- R10: An input presented while `in_ready` is 0 and withdrawn before `in_ready` returns to 1 is ignored. The pending result comes out unchanged, and no further result follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_slot_vld | input | LANES | Per-slot valid of the offered beat |
| in_bytes | input | LANES*WIN*8 | Byte windows, slot s at [s*WIN*8 +: WIN*8] |
| in_ready | output | 1 | Stage can accept a beat (low during penalty) |
| out_slot_vld | output | LANES | One-cycle pulse per reported slot |
| out_vec | output | LANES | Vector prefix seen |
| out_mask | output | LANES | Mask-instruction prefix seen |
| out_rex_vld | output | LANES | REX byte seen |
| out_rex_bits | output | LANES*4 | Low nibble of last REX |
| out_esc | output | LANES | Escape byte seen |
| out_opsz | output | LANES | Operand-size prefix seen |
| out_adsz | output | LANES | Address-size prefix seen |
| out_lock | output | LANES | Lock prefix seen |
| out_seg_vld | output | LANES | Segment override seen |
| out_seg | output | LANES*3 | Code of last segment override |
| out_rep | output | LANES*2 | Last repeat prefix kind |
| out_opc_ptr | output | LANES*PTR_W | Opcode byte index |

## Verification
Some rules are checked on every cycle. These cover how ready and valid are shaped at the ports: ready is never low for more than two cycles in a row, no result appears while ready is low, a result appears when ready comes back, and a cheap beat with ready still high is reported on the next cycle with its slot mask. The opcode index must also never exceed the window size. Other properties depend on knowing which bytes were sent, so only the bench's directed scenarios can show them. These are the per-prefix flag values, the segment, REX and repeat last-wins rules, a scan that stops after the escape byte, and a beat offered during a stall being ignored.

// File: rtl/pfx_pkg.sv
// Shared types and byte classification for the prefix classifier stage.
// Assumes 64-bit mode, so 0x40-0x4F are always REX bytes.
package pfx_pkg;

    typedef enum logic [3:0] {
        PK_NONE, PK_VEC, PK_MASK, PK_REX, PK_ESC,
        PK_OPSZ, PK_ADSZ, PK_LOCK, PK_SEG, PK_REPNE, PK_REPE
    } pfx_kind_e;

    typedef struct packed {
        pfx_kind_e  kind;
        logic       slow;
        logic       term;
        logic [2:0] seg;
    } byte_cls_t;

    typedef struct packed {
        logic       vec;
        logic       mask;
        logic       esc;
        logic       opsz;
        logic       adsz;
        logic       lock;
        logic       rex_v;
        logic [3:0] rex;
        logic       seg_v;
        logic [2:0] seg;
        logic [1:0] rep;
    } lane_flags_t;

    localparam logic [1:0] REP_NE = 2'b01;
    localparam logic [1:0] REP_E  = 2'b10;

    // Map one byte to its prefix class.
    function automatic byte_cls_t classify(input logic [7:0] b);
        byte_cls_t c;
        c = '{kind: PK_NONE, slow: 1'b0, term: 1'b0, seg: 3'd0};
        case (b)
            8'h62:        begin c.kind = PK_VEC;  c.term = 1'b1; end
            8'hC4, 8'hC5: begin c.kind = PK_MASK; c.term = 1'b1; end
            8'h0F:        begin c.kind = PK_ESC;  c.term = 1'b1; end
            8'h66:        begin c.kind = PK_OPSZ; c.slow = 1'b1; end
            8'h67:        begin c.kind = PK_ADSZ; c.slow = 1'b1; end
            8'hF0:        begin c.kind = PK_LOCK; c.slow = 1'b1; end
            8'hF2:        begin c.kind = PK_REPNE; c.slow = 1'b1; end
            8'hF3:        begin c.kind = PK_REPE; c.slow = 1'b1; end
            8'h26:        begin c.kind = PK_SEG; c.slow = 1'b1; c.seg = 3'd0; end
            8'h2E:        begin c.kind = PK_SEG; c.slow = 1'b1; c.seg = 3'd1; end
            8'h36:        begin c.kind = PK_SEG; c.slow = 1'b1; c.seg = 3'd2; end
            8'h3E:        begin c.kind = PK_SEG; c.slow = 1'b1; c.seg = 3'd3; end
            8'h64:        begin c.kind = PK_SEG; c.slow = 1'b1; c.seg = 3'd4; end
            8'h65:        begin c.kind = PK_SEG; c.slow = 1'b1; c.seg = 3'd5; end
            default: begin
                if (b[7:4] == 4'h4) c.kind = PK_REX;
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pfx_byte_class.sv
// Classifies a single instruction byte. Purely combinational, no state.
module pfx_byte_class
    import pfx_pkg::*;
(
    input  logic [7:0] byte_i,
    output byte_cls_t  cls_o
);

    // Drive the class from the shared table.
    always_comb cls_o = classify(byte_i);

endmodule

// File: rtl/pfx_lane_scan.sv
// Scans one byte window from byte 0 and accumulates prefix flags.
// Stops at the first non-prefix byte or just after a terminating prefix.
// Assumes the window holds the start of one instruction at byte 0.
module pfx_lane_scan
    import pfx_pkg::*;
#(
    parameter int WIN   = 8,
    parameter int PTR_W = $clog2(WIN + 1)
) (
    input  logic [WIN*8-1:0]  win_i,
    output lane_flags_t       flags_o,
    output logic [PTR_W-1:0]  opc_ptr_o,
    output logic              slow_o
);

    byte_cls_t cls [WIN];

    genvar gk;
    generate
        for (gk = 0; gk < WIN; gk++) begin : g_byte
            pfx_byte_class u_cls (
                .byte_i (win_i[gk*8 +: 8]),
                .cls_o  (cls[gk])
            );
        end
    endgenerate

    // Priority walk over the classified bytes.
    always_comb begin
        logic done;
        flags_o   = '0;
        opc_ptr_o = PTR_W'(WIN);
        slow_o    = 1'b0;
        done      = 1'b0;
        for (int k = 0; k < WIN; k++) begin
            if (!done) begin
                if (cls[k].kind == PK_NONE) begin
                    done      = 1'b1;
                    opc_ptr_o = PTR_W'(k);
                end else begin
                    slow_o = slow_o | cls[k].slow;
                    case (cls[k].kind)
                        PK_VEC:   flags_o.vec  = 1'b1;
                        PK_MASK:  flags_o.mask = 1'b1;
                        PK_ESC:   flags_o.esc  = 1'b1;
                        PK_OPSZ:  flags_o.opsz = 1'b1;
                        PK_ADSZ:  flags_o.adsz = 1'b1;
                        PK_LOCK:  flags_o.lock = 1'b1;
                        PK_REPNE: flags_o.rep  = REP_NE;
                        PK_REPE:  flags_o.rep  = REP_E;
                        PK_REX: begin
                            flags_o.rex_v = 1'b1;
                            flags_o.rex   = win_i[k*8 +: 4];
                        end
                        PK_SEG: begin
                            flags_o.seg_v = 1'b1;
                            flags_o.seg   = cls[k].seg;
                        end
                        default: ;
                    endcase
                    if (cls[k].term) begin
                        done      = 1'b1;
                        opc_ptr_o = PTR_W'(k + 1);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/pfx_penalty_ctl.sv
// Owns the ready/valid timing of the stage. A cheap beat is reported on
// the next cycle. A beat with any slow prefix holds ready low for PEN_CYC
// cycles and is then reported. Assumes accept_i is only high with ready_o.
module pfx_penalty_ctl #(
    parameter int LANES   = 2,
    parameter int PEN_CYC = 2,
    parameter int CNT_W   = $clog2(PEN_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept_i,
    input  logic             slow_i,
    input  logic [LANES-1:0] mask_i,
    output logic             ready_o,
    output logic [LANES-1:0] out_vld_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [LANES-1:0] pend_q;

    // Ready is high whenever no penalty is running.
    always_comb ready_o = (cnt_q == '0);

    // Penalty countdown and the one-cycle output valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            pend_q    <= '0;
            out_vld_o <= '0;
        end else begin
            out_vld_o <= '0;
            if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) out_vld_o <= pend_q;
            end else if (accept_i) begin
                if (slow_i) begin
                    cnt_q  <= CNT_W'(PEN_CYC);
                    pend_q <= mask_i;
                end else begin
                    out_vld_o <= mask_i;
                end
            end
        end
    end

endmodule

// File: rtl/pfx_decode_stage.sv
// Top of the prefix classifier stage. It scans LANES byte windows in
// parallel, registers their flags when a beat is accepted, and applies a
// single shared penalty when any valid slot holds a slow prefix.
// Assumes the slot mask and bytes are stable while a beat is offered.
module pfx_decode_stage
    import pfx_pkg::*;
#(
    parameter int LANES   = 2,
    parameter int WIN     = 8,
    parameter int PEN_CYC = 2,
    parameter int PTR_W   = $clog2(WIN + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LANES-1:0]       in_slot_vld,
    input  logic [LANES*WIN*8-1:0] in_bytes,
    output logic                   in_ready,
    output logic [LANES-1:0]       out_slot_vld,
    output logic [LANES-1:0]       out_vec,
    output logic [LANES-1:0]       out_mask,
    output logic [LANES-1:0]       out_rex_vld,
    output logic [LANES*4-1:0]     out_rex_bits,
    output logic [LANES-1:0]       out_esc,
    output logic [LANES-1:0]       out_opsz,
    output logic [LANES-1:0]       out_adsz,
    output logic [LANES-1:0]       out_lock,
    output logic [LANES-1:0]       out_seg_vld,
    output logic [LANES*3-1:0]     out_seg,
    output logic [LANES*2-1:0]     out_rep,
    output logic [LANES*PTR_W-1:0] out_opc_ptr
);

    localparam int WIN_BITS = WIN * 8;

    logic             accept;
    logic [LANES-1:0] lane_slow;
    logic             slow_any;

    // A beat is taken when any slot is offered and the stage is free.
    always_comb accept = in_ready && (|in_slot_vld);

    // Only slots that are actually offered can charge the penalty.
    always_comb slow_any = |(lane_slow & in_slot_vld);

    genvar gl;
    generate
        for (gl = 0; gl < LANES; gl++) begin : g_lane
            lane_flags_t      flg_d, flg_q;
            logic [PTR_W-1:0] ptr_d, ptr_q;

            pfx_lane_scan #(.WIN(WIN), .PTR_W(PTR_W)) u_scan (
                .win_i     (in_bytes[gl*WIN_BITS +: WIN_BITS]),
                .flags_o   (flg_d),
                .opc_ptr_o (ptr_d),
                .slow_o    (lane_slow[gl])
            );

            // Latch this slot's scan result when the beat is accepted.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    flg_q <= '0;
                    ptr_q <= '0;
                end else if (accept) begin
                    flg_q <= flg_d;
                    ptr_q <= ptr_d;
                end
            end

            // Spread the held fields onto this slot's lane of the buses.
            always_comb begin
                out_vec[gl]                 = flg_q.vec;
                out_mask[gl]                = flg_q.mask;
                out_rex_vld[gl]             = flg_q.rex_v;
                out_rex_bits[gl*4 +: 4]     = flg_q.rex;
                out_esc[gl]                 = flg_q.esc;
                out_opsz[gl]                = flg_q.opsz;
                out_adsz[gl]                = flg_q.adsz;
                out_lock[gl]                = flg_q.lock;
                out_seg_vld[gl]             = flg_q.seg_v;
                out_seg[gl*3 +: 3]          = flg_q.seg;
                out_rep[gl*2 +: 2]          = flg_q.rep;
                out_opc_ptr[gl*PTR_W +: PTR_W] = ptr_q;
            end
        end
    endgenerate

    pfx_penalty_ctl #(.LANES(LANES), .PEN_CYC(PEN_CYC)) u_pen (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_i  (accept),
        .slow_i    (slow_any),
        .mask_i    (in_slot_vld),
        .ready_o   (in_ready),
        .out_vld_o (out_slot_vld)
    );

endmodule

// File: rtl/pfx_decode_stage_chk.sv
// Port-level timing checks for the prefix classifier stage, bound to the top.
module pfx_decode_stage_chk #(
    parameter int LANES = 2,
    parameter int WIN   = 8,
    parameter int PTR_W = $clog2(WIN + 1)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [LANES-1:0]       in_slot_vld,
    input logic                   in_ready,
    input logic [LANES-1:0]       out_slot_vld,
    input logic [LANES*PTR_W-1:0] out_opc_ptr
);

    AST_RESET_STATE: assert property (@(posedge clk)
        $rose(rst_n) |-> in_ready && out_slot_vld == '0); // R1

    AST_FAST_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_ready && (|in_slot_vld)) && in_ready) |-> out_slot_vld == $past(in_slot_vld)); // R2

    AST_NO_RESULT_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> out_slot_vld == '0); // R3

    AST_RESULT_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ready) |-> out_slot_vld != '0); // R3

    AST_STALL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!in_ready) && !in_ready) |=> in_ready); // R4

    AST_RESULT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_slot_vld != '0) |-> ($past(in_ready && (|in_slot_vld)) || $past(!in_ready))); // R10

    genvar gl;
    generate
        for (gl = 0; gl < LANES; gl++) begin : g_ptr
            AST_PTR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
                out_opc_ptr[gl*PTR_W +: PTR_W] <= PTR_W'(WIN)); // R5
        end
    endgenerate

endmodule

bind pfx_decode_stage pfx_decode_stage_chk #(.LANES(LANES), .WIN(WIN), .PTR_W(PTR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_slot_vld  (in_slot_vld),
    .in_ready     (in_ready),
    .out_slot_vld (out_slot_vld),
    .out_opc_ptr  (out_opc_ptr)
);

// File: tb/pfx_decode_stage_tb_top.sv
// Directed bench for the prefix classifier stage at default parameters.
module pfx_decode_stage_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   in_slot_vld = '0;
    logic [127:0] in_bytes = '0;
    logic         in_ready;
    logic [1:0]   out_slot_vld, out_vec, out_mask, out_rex_vld, out_esc;
    logic [1:0]   out_opsz, out_adsz, out_lock, out_seg_vld;
    logic [7:0]   out_rex_bits;
    logic [5:0]   out_seg;
    logic [3:0]   out_rep;
    logic [7:0]   out_opc_ptr;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pfx_decode_stage dut_i (
        .clk(clk), .rst_n(rst_n), .in_slot_vld(in_slot_vld), .in_bytes(in_bytes),
        .in_ready(in_ready), .out_slot_vld(out_slot_vld), .out_vec(out_vec),
        .out_mask(out_mask), .out_rex_vld(out_rex_vld), .out_rex_bits(out_rex_bits),
        .out_esc(out_esc), .out_opsz(out_opsz), .out_adsz(out_adsz),
        .out_lock(out_lock), .out_seg_vld(out_seg_vld), .out_seg(out_seg),
        .out_rep(out_rep), .out_opc_ptr(out_opc_ptr)
    );

    // Expected field word: vec mask esc opsz adsz lock rexv rex segv seg rep ptr
    function automatic logic [20:0] mk(bit vec, bit msk, bit esc, bit opsz, bit adsz,
                                       bit lock, bit rexv, logic [3:0] rex, bit segv,
                                       logic [2:0] seg, logic [1:0] rep, logic [3:0] ptr);
        return {vec, msk, esc, opsz, adsz, lock, rexv, rex, segv, seg, rep, ptr};
    endfunction

    function automatic logic [20:0] act(int l);
        return {out_vec[l], out_mask[l], out_esc[l], out_opsz[l], out_adsz[l], out_lock[l],
                out_rex_vld[l], out_rex_bits[l*4 +: 4], out_seg_vld[l], out_seg[l*3 +: 3],
                out_rep[l*2 +: 2], out_opc_ptr[l*4 +: 4]};
    endfunction

    task automatic chk(string req, string what, logic [31:0] a, logic [31:0] e);
        total++;
        if (a !== e) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, a, e);
        end
    endtask

    // Offer one beat, measure latency and stall length, compare the fields.
    task automatic run_one(string req, logic [63:0] b0, logic [63:0] b1, logic [1:0] m,
                           int exp_lat, logic [20:0] e0, logic [20:0] e1);
        int lat = 0;
        int low = 0;
        @(negedge clk);
        in_bytes = {b1, b0};
        in_slot_vld = m;
        while (lat < 6) begin
            @(negedge clk);
            in_slot_vld = '0;
            lat++;
            if (!in_ready) low++;
            if (out_slot_vld != '0) break;
        end
        chk(req, "latency", lat, exp_lat);
        chk(req, "ready-low cycles", low, (exp_lat == 3) ? 2 : 0);
        chk(req, "slot mask", out_slot_vld, m);
        if (m[0]) chk(req, "slot0 fields", act(0), e0);
        if (m[1]) chk(req, "slot1 fields", act(1), e1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "ready", in_ready, 1);
        chk("R1", "out valid", out_slot_vld, 0);
    endtask

    task automatic t_cheap_pair();
        // R2 R9: vector prefix in slot 0, REX then mask prefix in slot 1
        run_one("R2", 64'h90_62, 64'h90_C5_48, 2'b11, 1,
                mk(1,0,0,0,0,0,0,4'h0,0,3'd0,2'b00,4'd1),
                mk(0,1,0,0,0,0,1,4'h8,0,3'd0,2'b00,4'd2));
    endtask

    task automatic t_slot1_only();
        // R7 R9: REX 0x4D then escape, slot 1 alone
        run_one("R9", 64'h0, 64'h90_0F_4D, 2'b10, 1, '0,
                mk(0,0,1,0,0,0,1,4'hD,0,3'd0,2'b00,4'd2));
    endtask

    task automatic t_scan_stops();
        // R5: 0x66 after the escape byte is not a prefix and costs nothing
        run_one("R5", 64'h90_66_0F, 64'h0, 2'b01, 1,
                mk(0,0,1,0,0,0,0,4'h0,0,3'd0,2'b00,4'd1), '0);
        run_one("R5", 64'h90, 64'h0, 2'b01, 1, mk(0,0,0,0,0,0,0,4'h0,0,3'd0,2'b00,4'd0), '0);
    endtask

    task automatic t_single_slow();
        run_one("R3", 64'h90_66, 64'h0, 2'b01, 3,
                mk(0,0,0,1,0,0,0,4'h0,0,3'd0,2'b00,4'd1), '0);
    endtask

    task automatic t_many_slow();
        // R4 R6 R8: five slow prefixes in slot 0, one in slot 1, one penalty
        run_one("R4", 64'h90_66_F3_2E_67_F0, 64'h90_65, 2'b11, 3,
                mk(0,0,0,1,1,1,0,4'h0,1,3'd1,2'b10,4'd5),
                mk(0,0,0,0,0,0,0,4'h0,1,3'd5,2'b00,4'd1));
    endtask

    task automatic t_last_wins();
        // R6 R7 R8: later segment, repeat and REX bytes override earlier ones
        run_one("R6", 64'h90_4A_41_F2_F3_64_26, 64'h0, 2'b01, 3,
                mk(0,0,0,0,0,0,1,4'hA,1,3'd4,2'b01,4'd6), '0);
        run_one("R8", 64'h90_3E_36_F3, 64'h0, 2'b01, 3,
                mk(0,0,0,0,0,0,0,4'h0,1,3'd3,2'b10,4'd3), '0);
    endtask

    task automatic t_all_prefix();
        // R5: no opcode inside the window gives index WIN
        run_one("R5", 64'h6666666666666666, 64'h0, 2'b01, 3,
                mk(0,0,0,1,0,0,0,4'h0,0,3'd0,2'b00,4'd8), '0);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        in_bytes = {64'h0, 64'h90_62};
        in_slot_vld = 2'b01;
        @(negedge clk);
        chk("R2", "first ready", in_ready, 1);
        chk("R2", "first valid", out_slot_vld, 2'b01);
        chk("R2", "first fields", act(0), mk(1,0,0,0,0,0,0,4'h0,0,3'd0,2'b00,4'd1));
        in_bytes = {64'h0, 64'h90_C4};
        @(negedge clk);
        in_slot_vld = '0;
        chk("R2", "second valid", out_slot_vld, 2'b01);
        chk("R2", "second fields", act(0), mk(0,1,0,0,0,0,0,4'h0,0,3'd0,2'b00,4'd1));
    endtask

    task automatic t_ignore_in_stall();
        @(negedge clk);
        in_bytes = {64'h0, 64'h90_F0};
        in_slot_vld = 2'b01;
        @(negedge clk);
        chk("R10", "ready in stall", in_ready, 0);
        in_bytes = {64'h0, 64'h90_62};
        in_slot_vld = 2'b11;
        @(negedge clk);
        in_slot_vld = '0;
        @(negedge clk);
        chk("R10", "pending mask", out_slot_vld, 2'b01);
        chk("R10", "pending fields", act(0), mk(0,0,0,0,0,1,0,4'h0,0,3'd0,2'b00,4'd1));
        @(negedge clk);
        chk("R10", "no extra result", out_slot_vld, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cheap_pair();
        t_slot1_only();
        t_scan_stops();
        t_single_slow();
        t_many_slow();
        t_last_wins();
        t_all_prefix();
        t_back_to_back();
        t_ignore_in_stall();
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule